// File: doc/BRIEF.md
# Fractional-N Feedback Divider Controller

This block drives the feedback divider of a fractional-N synthesizer loop. It runs on the fast input clock and divides it by a value that changes from one output period to the next. Over many periods the average ratio equals an integer word plus a fractional word over a fixed power-of-two modulus of 2^FRAC_W. With the default 25-bit fraction, the frequency step is the comparison rate divided by 2^25, which is about 0.3 Hz at a 10 MHz comparison rate.

The fraction comes from a third-order cascade of three error-feedback accumulators. At each output pulse the cascade produces a small signed offset, which is added to the active integer word. The sum is registered and becomes the count loaded at the next pulse. A down-counter emits a one-cycle pulse when it reaches zero and then reloads.

Software-side values pass through a shadow stage. A load strobe captures a legal pair of words. The pair becomes active only at an output pulse, so no period is built from a partly written setting.

Top module: `fracn_div_ctrl`

## Requirements
- R1: Over any 2^FRAC_W consecutive periods with a constant active setting, the total number of input cycles is within ±3 of 2^FRAC_W·INT + FRAC.
- R2: At each pulse the three accumulators step as s1=a1+F, s2=a2+s1, s3=a3+s2 (each modulo 2^FRAC_W, carries c1,c2,c3). The offset is c1+(c2−c2')+(c3−2c3'+c3''), where primes mark the carries of the previous one and two steps. The registered divide value becomes INT+offset, and the counter uses it as the period length at the following pulse.
- R3: The offset always lies in the range −3 to +4.
- R4: While the active FRAC is zero, a pulse clears all accumulators and carry history, and the next divide value is exactly the active INT.
- R5: load_i writes the shadow pair. Shadow moves to active only on a pulse, and active stays constant between pulses. A setting loaded before pulse k sets the period that starts at pulse k+2. If several loads come before one pulse, the last one counts.
- R6: A load whose int_i is below INT_MIN (23 by default) is ignored for both words.
- R7: In reset, shadow and active hold INT=RST_INT and FRAC=0, the divide value is RST_INT and the counter is zero, so div_pulse_o is high. The first reload happens on the first clock edge after release, and periods of RST_INT follow.
- R8: The counter counts down once per input cycle and pulses for one cycle at zero. Divide values up to 2^INT_W−1+4 do not wrap.
- R9: With INT=INT_MIN under full dither, no period is shorter than INT_MIN−3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Strobe that captures int_i and frac_i into the shadow stage |
| int_i | input | INT_W | Integer divide word |
| frac_i | input | FRAC_W | Fractional numerator over 2^FRAC_W |
| div_pulse_o | output | 1 | One-cycle pulse per divided period |

## Verification
The bench builds the block with FRAC_W=8, INT_W=12 and INT_MIN=23. A full fractional cycle of 256 periods therefore fits in a few thousand input cycles, and the ±3 bound on the average ratio can be checked exactly over whole windows. Keeping the full 12-bit integer brings the 4095+4 corner and the 23−3 floor within reach. A scoreboard compares every pulse interval against a reference model of the cascade, which exposes the two-pulse latency of new settings and any change to the carry weighting.

// File: rtl/fracn_div_pkg.sv
package fracn_div_pkg;
  localparam int unsigned ORDER = 3;
  localparam int unsigned OFF_W = 4;
  typedef logic signed [OFF_W-1:0] off_t;
endpackage

// File: rtl/fracn_mash.sv
module fracn_mash
  import fracn_div_pkg::*;
#(
  parameter int unsigned FRAC_W = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clear_i,
  input  logic [FRAC_W-1:0] frac_i,
  output off_t              off_o
);
  logic [FRAC_W-1:0] sum [ORDER];
  logic [ORDER-1:0]  cry;
  logic              c2_p, c3_p, c3_pp;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] addend;
    if (g == 0) begin : g_head
      assign addend = frac_i;
    end else begin : g_tail
      assign addend = sum[g-1];
    end
    assign {cry[g], sum[g]} = {1'b0, acc_q} + {1'b0, addend};
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     acc_q <= '0;
      else if (step_i) acc_q <= clear_i ? '0 : sum[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c2_p  <= 1'b0;
      c3_p  <= 1'b0;
      c3_pp <= 1'b0;
    end else if (step_i) begin
      c2_p  <= clear_i ? 1'b0 : cry[1];
      c3_p  <= clear_i ? 1'b0 : cry[2];
      c3_pp <= clear_i ? 1'b0 : c3_p;
    end
  end

  // modulo-16 sum read back as signed; true range is -3..+4
  logic [OFF_W-1:0] raw;
  always_comb begin
    raw = {3'b0, cry[0]} + {3'b0, cry[1]} - {3'b0, c2_p}
        + {3'b0, cry[2]} - {2'b0, c3_p, 1'b0} + {3'b0, c3_pp};
    off_o = off_t'(raw);
  end
endmodule

// File: rtl/fracn_div_cnt.sv
module fracn_div_cnt #(
  parameter int unsigned CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] load_val_i,
  output logic          pulse_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  assign pulse_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (pulse_o) cnt_q <= load_val_i - CW'(1);
    else              cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fracn_div_pkg::*;
#(
  parameter int unsigned INT_W   = 12,
  parameter int unsigned FRAC_W  = 25,
  parameter int unsigned INT_MIN = 23,
  parameter int unsigned RST_INT = INT_MIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              div_pulse_o
);
  localparam int unsigned CW = INT_W + 1;

  logic [INT_W-1:0]  sh_int, act_int;
  logic [FRAC_W-1:0] sh_frac, act_frac;
  logic [CW-1:0]     n_q, n_sum, cnt;
  off_t              mash_off;
  logic              frac_zero;

  assign frac_zero = (act_frac == '0);
  assign n_sum = {1'b0, act_int} + {{(CW-OFF_W){mash_off[OFF_W-1]}}, mash_off};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_int  <= INT_W'(RST_INT);
      sh_frac <= '0;
    end else if (load_i && (int_i >= INT_W'(INT_MIN))) begin
      sh_int  <= int_i;
      sh_frac <= frac_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_int  <= INT_W'(RST_INT);
      act_frac <= '0;
      n_q      <= CW'(RST_INT);
    end else if (div_pulse_o) begin
      act_int  <= sh_int;
      act_frac <= sh_frac;
      n_q      <= frac_zero ? {1'b0, act_int} : n_sum;
    end
  end

  fracn_mash #(.FRAC_W(FRAC_W)) u_mash (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (div_pulse_o),
    .clear_i (frac_zero),
    .frac_i  (act_frac),
    .off_o   (mash_off)
  );

  fracn_div_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_val_i (n_q),
    .pulse_o    (div_pulse_o),
    .cnt_o      (cnt)
  );
endmodule

// File: rtl/fracn_div_ctrl_chk.sv
module fracn_div_ctrl_chk
  import fracn_div_pkg::*;
#(
  parameter int unsigned INT_W   = 12,
  parameter int unsigned FRAC_W  = 25,
  parameter int unsigned INT_MIN = 23
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pulse_i,
  input logic [INT_W:0]    cnt_i,
  input logic [INT_W:0]    n_i,
  input off_t              off_i,
  input logic [INT_W-1:0]  act_int_i,
  input logic [FRAC_W-1:0] act_frac_i,
  input logic [INT_W-1:0]  sh_int_i
);
  localparam int unsigned CW = INT_W + 1;

  a_r2_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i |=> cnt_i == $past(n_i) - CW'(1));

  a_r8_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> cnt_i == $past(cnt_i) - CW'(1));

  a_r3_offset_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i >= -4'sd3) && (off_i <= 4'sd4));

  a_r4_zero_frac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_i && act_frac_i == '0) |=> n_i == {1'b0, $past(act_int_i)});

  a_r5_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pulse_i |=> $stable(act_int_i) && $stable(act_frac_i));

  a_r6_shadow_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_int_i >= INT_W'(INT_MIN));

  a_r9_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_i >= CW'(INT_MIN - 3));
endmodule

bind fracn_div_ctrl fracn_div_ctrl_chk #(
  .INT_W(INT_W), .FRAC_W(FRAC_W), .INT_MIN(INT_MIN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pulse_i    (div_pulse_o),
  .cnt_i      (cnt),
  .n_i        (n_q),
  .off_i      (mash_off),
  .act_int_i  (act_int),
  .act_frac_i (act_frac),
  .sh_int_i   (sh_int)
);

// File: tb/fracn_div_ctrl_tb_top.sv
module fracn_div_ctrl_tb_top;
  localparam int INT_W   = 12;
  localparam int FRAC_W  = 8;
  localparam int INT_MIN = 23;
  localparam int MODV    = 1 << FRAC_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              load_i = 1'b0;
  logic [INT_W-1:0]  int_i = '0;
  logic [FRAC_W-1:0] frac_i = '0;
  logic              div_pulse_o;

  fracn_div_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .INT_MIN(INT_MIN)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i),
    .int_i(int_i), .frac_i(frac_i), .div_pulse_o(div_pulse_o)
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_req = "R7";
  int exp_q[$];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  // monitor: measures pulse intervals and pops expected lengths
  int edge_idx = 0, last_edge = 0, mon_cnt = 0, mon_sum = 0, mon_last = 0;
  int mon_min = 1 << 30, mon_max = 0;
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      edge_idx++;
      if (!rst_ni) last_edge = edge_idx;
      else if (div_pulse_o) begin
        int iv;
        iv = edge_idx - last_edge;
        last_edge = edge_idx;
        mon_cnt++;
        mon_sum += iv;
        mon_last = iv;
        if (iv < mon_min) mon_min = iv;
        if (iv > mon_max) mon_max = iv;
        // R2 exact period sequence against reference model
        if (exp_q.size() == 0) chk({cur_req, "/R2"}, iv, -1);
        else chk({cur_req, "/R2"}, iv, exp_q.pop_front());
      end
    end
  end

  // reference model of the requirements, evaluated before each rising edge
  int m_sh_int = INT_MIN, m_sh_frac = 0, m_act_int = INT_MIN, m_act_frac = 0;
  int m_nq = INT_MIN, m_pulses = 0;
  int ma[3] = '{0, 0, 0};
  int mc2p = 0, mc3p = 0, mc3pp = 0;

  task automatic model_step();
    if (div_pulse_o) begin
      exp_q.push_back(m_nq);
      if (m_act_frac == 0) begin
        ma = '{0, 0, 0};
        mc2p = 0; mc3p = 0; mc3pp = 0;
        m_nq = m_act_int;
      end else begin
        int s1, s2, s3, c1, c2, c3;
        s1 = ma[0] + m_act_frac; c1 = s1 / MODV; s1 = s1 % MODV;
        s2 = ma[1] + s1;         c2 = s2 / MODV; s2 = s2 % MODV;
        s3 = ma[2] + s2;         c3 = s3 / MODV; s3 = s3 % MODV;
        ma = '{s1, s2, s3};
        m_nq = m_act_int + c1 + (c2 - mc2p) + (c3 - 2 * mc3p + mc3pp);
        mc3pp = mc3p; mc3p = c3; mc2p = c2;
      end
      m_act_int = m_sh_int;
      m_act_frac = m_sh_frac;
      m_pulses++;
    end
    if (load_i && int_i >= INT_W'(INT_MIN)) begin
      m_sh_int = int_i;
      m_sh_frac = frac_i;
    end
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk_i);
  endtask

  task automatic load(int iv, int fv);
    load_i = 1'b1; int_i = INT_W'(iv); frac_i = FRAC_W'(fv);
    cycle();
    load_i = 1'b0;
  endtask

  task automatic run_periods(int n);
    int target;
    target = m_pulses + n;
    while (m_pulses < target) cycle();
  endtask

  // R1 average ratio and R3 offset spread over one full fractional cycle
  task automatic avg_check(int iv, int fv);
    int c0, s0, d;
    run_periods(4);
    c0 = mon_cnt; s0 = mon_sum;
    mon_min = 1 << 30; mon_max = 0;
    while (mon_cnt < c0 + MODV) cycle();
    d = (mon_sum - s0) - (MODV * iv + fv);
    chk("R1", (d >= -3 && d <= 3) ? 1 : 0, 1);
    if (d < -3 || d > 3) $display("  R1 deviation %0d cycles", d);
    chk("R3", (mon_min >= iv - 3 && mon_max <= iv + 4) ? 1 : 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R7", int'(div_pulse_o), 1);
    rst_ni = 1'b1;
    cur_req = "R7";
    run_periods(3);

    cur_req = "R4";
    load(30, 0);
    run_periods(5);
    chk("R4", mon_last, 30);

    cur_req = "R6";
    load(10, 50);
    run_periods(4);
    chk("R6", mon_last, 30);

    cur_req = "R1";
    load(27, 100);
    avg_check(27, 100);

    cur_req = "R5";
    load(35, 7);
    repeat (5) cycle();
    load(36, 3);
    run_periods(6);
    chk("R5", (mon_last >= 33 && mon_last <= 40) ? 1 : 0, 1);

    cur_req = "R9";
    load(INT_MIN, MODV - 1);
    avg_check(INT_MIN, MODV - 1);
    chk("R9", (mon_min >= INT_MIN - 3) ? 1 : 0, 1);

    cur_req = "R1";
    load(40, 1);
    avg_check(40, 1);

    cur_req = "R8";
    load(4095, MODV - 1);
    run_periods(6);
    chk("R8", (mon_last >= 4092 && mon_last <= 4099) ? 1 : 0, 1);

    cur_req = "R4";
    load(INT_MIN, 0);
    run_periods(5);
    chk("R4", mon_last, INT_MIN);

    repeat (4) cycle();
    finish_run();
  end
endmodule